// File: doc/BRIEF.md
# Dual Clock Synthesizer Serial Programmer

This block retunes two external frequency synthesizers, one for the core clock and one for the memory clock. Both sit on one two-wire serial link (serial clock and serial data). Each synthesizer has its own load strobe, and a single shared preload enable serves both. The block holds the current operating mode, which is either high-speed or power-save. It accepts one request at a time. A request either asks for the current mode (a query) or asks to switch to the other mode.

When a switch is accepted, the block looks up the multiplier value for each synthesizer in the new mode. It sends a 13-bit frame to the core synthesizer, strobes it, and then does the same for the memory synthesizer. It then returns the preload enable low, records the new mode and pulses `done_o`. Every pin change is followed by a settling interval of `GAP_TICKS` clock cycles. A request for the mode that is already active produces no pin activity and reports an "already in mode" status.

Top module: `clk_synth_prog`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `cur_mode_o` is 1 (power-save), and `sclk_o`, `sdata_o`, `preload_o`, `load_core_o` and `load_mem_o` are all 0.
- R2: A request with `query_i`=1 accepted while idle pulses `done_o` on the next cycle with `status_o`=2. It causes no pin change and leaves `cur_mode_o` unchanged.
- R3: A non-query request whose `mode_i` equals `cur_mode_o` pulses `done_o` on the next cycle with `status_o`=1 and causes no pin change.
- R4: Each synthesizer receives a 13-bit frame made of the T field (bits 12:11), then the N field (bits 10:9), then the M field (bits 8:0), sent MSB first. For each bit, `sdata_o` is set first, then `sclk_o` is driven low, then high. The receiver samples on the rising edge of `sclk_o`.
- R5: T and N are 0. For mode 0 (high-speed), M is 0x14 for the core and 0x18 for the memory. For mode 1 (power-save), M is 0x0E for the core and 0x10 for the memory.
- R6: Before each frame, `preload_o` goes high. Then the target load strobe and `sclk_o` are driven low. `preload_o` stays high on every rising edge of `sclk_o` and whenever a load strobe rises.
- R7: After the 13th bit, the target's load strobe is pulsed high once and then returned low. The core frame and its strobe complete before any memory frame bit is sent. The two strobes are never high together.
- R8: Any two successive pin changes are at least `GAP_TICKS` clock cycles apart.
- R9: `busy_o` is high from acceptance of a switch until it completes. Requests made while busy are ignored, and `done_o` is never high while `busy_o` is high.
- R10: `cur_mode_o` changes only at completion of a switch, in the cycle in which `done_o` pulses with `status_o`=0. `preload_o` is already low by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, sampled while idle |
| mode_i | input | 1 | Requested mode: 0 high-speed, 1 power-save |
| query_i | input | 1 | Status query only, no programming |
| busy_o | output | 1 | Switch sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 programmed, 1 already in mode, 2 query |
| cur_mode_o | output | 1 | Current mode |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| preload_o | output | 1 | Shared preload enable |
| load_core_o | output | 1 | Core synthesizer load strobe |
| load_mem_o | output | 1 | Memory synthesizer load strobe |

## Verification
The assertions check the local pin relationships on every cycle. Data stays stable across each serial clock rise, preload is high at every clock rise and strobe rise, the two strobes never overlap, the mode changes only with a successful completion, and done never coincides with busy. Only the bench scenarios can show the frame contents and bit counts for each mode and synthesizer, the ordering of core before memory, and the minimum spacing between pin changes. The same applies to the one-cycle latency and the absence of pin activity for queries and same-mode requests, and to a request made during a switch being dropped.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;
  localparam int T_W     = 2;
  localparam int N_W     = 2;
  localparam int M_W     = 9;
  localparam int FRAME_W = T_W + N_W + M_W;
  localparam int IDX_W   = $clog2(FRAME_W);

  localparam logic MODE_FAST = 1'b0;
  localparam logic MODE_SAVE = 1'b1;

  typedef enum logic [1:0] {
    STAT_OK    = 2'd0,
    STAT_SAME  = 2'd1,
    STAT_QUERY = 2'd2
  } stat_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_ARM, ST_DAT, ST_CLO, ST_CHI, ST_LDH, ST_LDL, ST_END
  } step_e;

  // sel: 0 core, 1 memory
  function automatic logic [M_W-1:0] m_value(input logic mode, input logic sel);
    if (mode == MODE_FAST) return sel ? M_W'(9'h18) : M_W'(9'h14);
    else                   return sel ? M_W'(9'h10) : M_W'(9'h0E);
  endfunction
endpackage

// File: rtl/clk_synth_gap_timer.sv
module clk_synth_gap_timer #(
  parameter int GAP_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int CW = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(GAP_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= RELOAD;
      act_q <= 1'b1;
    end else if (act_q && cnt_q == '0) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = act_q && (cnt_q == '0);

  // R8
  gap_no_early_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && GAP_TICKS > 1) |=> !expire_o);
endmodule

// File: rtl/clk_synth_frame.sv
module clk_synth_frame
  import clk_synth_pkg::*;
(
  input  logic             mode_i,
  input  logic             sel_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame;

  always_comb begin
    frame = {T_W'(0), N_W'(0), m_value(mode_i, sel_i)};
    bit_o = (idx_i <= LAST) ? frame[LAST - idx_i] : 1'b0;
  end
endmodule

// File: rtl/clk_synth_prog.sv
module clk_synth_prog
  import clk_synth_pkg::*;
#(
  parameter int GAP_TICKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       mode_i,
  input  logic       query_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] status_o,
  output logic       cur_mode_o,
  output logic       sclk_o,
  output logic       sdata_o,
  output logic       preload_o,
  output logic       load_core_o,
  output logic       load_mem_o
);
  localparam int NSYN = 2;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

  step_e            step_q;
  logic             sel_q, tgt_q, cur_q;
  logic [IDX_W-1:0] idx_q, nxt_idx;
  logic [NSYN-1:0]  load_q;
  logic             sclk_q, sdata_q, preload_q, done_q;
  stat_e            stat_q;
  logic             expire, fbit, prog_start, tmr_start;

  assign prog_start = (step_q == ST_IDLE) && req_i && !query_i && (mode_i != cur_q);
  assign tmr_start  = prog_start || (expire && step_q != ST_END && step_q != ST_IDLE);
  assign nxt_idx    = (step_q == ST_ARM) ? '0 : idx_q + 1'b1;

  clk_synth_gap_timer #(.GAP_TICKS(GAP_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .expire_o(expire)
  );

  clk_synth_frame u_frame (
    .mode_i(tgt_q),
    .sel_i (sel_q),
    .idx_i (nxt_idx),
    .bit_o (fbit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q    <= ST_IDLE;
      sel_q     <= 1'b0;
      tgt_q     <= MODE_SAVE;
      cur_q     <= MODE_SAVE;
      idx_q     <= '0;
      load_q    <= '0;
      sclk_q    <= 1'b0;
      sdata_q   <= 1'b0;
      preload_q <= 1'b0;
      done_q    <= 1'b0;
      stat_q    <= STAT_OK;
    end else begin
      done_q <= 1'b0;
      if (step_q == ST_IDLE) begin
        if (req_i) begin
          if (query_i) begin
            done_q <= 1'b1;
            stat_q <= STAT_QUERY;
          end else if (mode_i == cur_q) begin
            done_q <= 1'b1;
            stat_q <= STAT_SAME;
          end else begin
            tgt_q     <= mode_i;
            sel_q     <= 1'b0;
            step_q    <= ST_PRE;
            preload_q <= 1'b1;
          end
        end
      end else if (expire) begin
        unique case (step_q)
          ST_PRE: begin
            step_q        <= ST_ARM;
            load_q[sel_q] <= 1'b0;
            sclk_q        <= 1'b0;
          end
          ST_ARM: begin
            step_q  <= ST_DAT;
            idx_q   <= nxt_idx;
            sdata_q <= fbit;
          end
          ST_DAT: begin
            step_q <= ST_CLO;
            sclk_q <= 1'b0;
          end
          ST_CLO: begin
            step_q <= ST_CHI;
            sclk_q <= 1'b1;
          end
          ST_CHI: begin
            if (idx_q == LAST) begin
              step_q        <= ST_LDH;
              load_q[sel_q] <= 1'b1;
            end else begin
              step_q  <= ST_DAT;
              idx_q   <= nxt_idx;
              sdata_q <= fbit;
            end
          end
          ST_LDH: begin
            step_q        <= ST_LDL;
            load_q[sel_q] <= 1'b0;
          end
          ST_LDL: begin
            if (!sel_q) begin
              sel_q     <= 1'b1;
              step_q    <= ST_PRE;
              preload_q <= 1'b1;
            end else begin
              step_q    <= ST_END;
              preload_q <= 1'b0;
            end
          end
          ST_END: begin
            step_q <= ST_IDLE;
            cur_q  <= tgt_q;
            done_q <= 1'b1;
            stat_q <= STAT_OK;
          end
          default: step_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o      = (step_q != ST_IDLE);
  assign done_o      = done_q;
  assign status_o    = stat_q;
  assign cur_mode_o  = cur_q;
  assign sclk_o      = sclk_q;
  assign sdata_o     = sdata_q;
  assign preload_o   = preload_q;
  assign load_core_o = load_q[0];
  assign load_mem_o  = load_q[1];

  // R4
  data_stable_at_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdata_o));
  // R6
  preload_at_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> preload_o);
  // R6
  preload_at_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(load_core_o) || $rose(load_mem_o)) |-> preload_o);
  // R7
  strobe_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_core_o && load_mem_o));
  // R9
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  // R10
  mode_change_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_mode_o) |-> (done_o && status_o == STAT_OK && !preload_o));
endmodule

// File: tb/clk_synth_prog_tb.sv
module clk_synth_prog_tb;
  localparam int GAP = 3;
  localparam int TMO = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0, mode_i = 1'b0, query_i = 1'b0;
  logic busy_o, done_o, cur_mode_o, sclk_o, sdata_o, preload_o, load_core_o, load_mem_o;
  logic [1:0] status_o;

  always #2 clk = ~clk;

  clk_synth_prog #(.GAP_TICKS(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .mode_i(mode_i), .query_i(query_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .cur_mode_o(cur_mode_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .preload_o(preload_o),
    .load_core_o(load_core_o), .load_mem_o(load_mem_o)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pin monitor, sampled on falling edge
  int cyc = 0, last_chg = 0, pin_changes = 0, gap_err = 0, pl_err = 0, done_cnt = 0;
  bit have_prev = 1'b0;
  logic [4:0] prev_pins = '0;
  logic [12:0] shreg = '0;
  int bitcnt = 0;
  int core_frames = 0, mem_frames = 0, core_bits = 0, mem_bits = 0;
  int core_cyc = 0, mem_cyc = 0;
  logic [12:0] core_val = '0, mem_val = '0;

  always @(negedge clk) begin
    logic [4:0] pins;
    cyc++;
    if (rst_n) begin
      pins = {sclk_o, sdata_o, preload_o, load_core_o, load_mem_o};
      if (done_o) done_cnt++;
      if (pins != prev_pins) begin
        pin_changes++;
        if (have_prev && (cyc - last_chg) < GAP) gap_err++;
        have_prev = 1'b1;
        last_chg  = cyc;
      end
      if (sclk_o && !prev_pins[4]) begin
        shreg = {shreg[11:0], sdata_o};
        bitcnt++;
        if (!preload_o || load_core_o || load_mem_o) pl_err++;
      end
      if (load_core_o && !prev_pins[1]) begin
        core_frames++; core_val = shreg; core_bits = bitcnt; core_cyc = cyc;
        shreg = '0; bitcnt = 0;
      end
      if (load_mem_o && !prev_pins[0]) begin
        mem_frames++; mem_val = shreg; mem_bits = bitcnt; mem_cyc = cyc;
        shreg = '0; bitcnt = 0;
      end
      prev_pins = pins;
    end
  end

  function automatic int exp_m(input logic mode, input logic mem);
    if (mode == 1'b0) return mem ? 24 : 20;
    else              return mem ? 16 : 14;
  endfunction

  logic exp_mode = 1'b1;

  task automatic do_req(input logic m, input logic q);
    int pc0, cf0, mf0, dc0, n;
    bit prog, poke;
    logic [1:0] st;
    logic cm, pl;
    prog = !q && (m != exp_mode);
    poke = prog;
    pc0 = pin_changes; cf0 = core_frames; mf0 = mem_frames; dc0 = done_cnt;
    @(negedge clk);
    req_i = 1'b1; mode_i = m; query_i = q;
    @(negedge clk);
    req_i = 1'b0;
    n = 1;
    while (!done_o && n < TMO) begin
      if (poke && n == 5) begin
        chk(busy_o, "R9 busy during switch", busy_o, 1);
        req_i = 1'b1; query_i = 1'b1; mode_i = !m;
      end else req_i = 1'b0;
      @(negedge clk);
      n++;
    end
    req_i = 1'b0; query_i = 1'b0;
    st = status_o; cm = cur_mode_o; pl = preload_o;
    chk(n < TMO, "R9 completion within timeout", n, TMO);
    repeat (4) @(negedge clk);
    chk(done_cnt - dc0 == 1, "R9 exactly one done per request", done_cnt - dc0, 1);
    if (q) begin
      chk(st == 2'd2, "R2 query status", st, 2);
      chk(cm == exp_mode, "R2 mode unchanged", cm, exp_mode);
      chk(n == 1, "R2 one-cycle latency", n, 1);
      chk(pin_changes == pc0, "R2 no pin activity", pin_changes - pc0, 0);
    end else if (!prog) begin
      chk(st == 2'd1, "R3 already-in-mode status", st, 1);
      chk(cm == exp_mode, "R3 mode unchanged", cm, exp_mode);
      chk(n == 1, "R3 one-cycle latency", n, 1);
      chk(pin_changes == pc0, "R3 no pin activity", pin_changes - pc0, 0);
    end else begin
      exp_mode = m;
      chk(st == 2'd0, "R10 programmed status", st, 0);
      chk(cm == m, "R10 new mode", cm, m);
      chk(!pl, "R10 preload low at done", pl, 0);
      chk(core_frames - cf0 == 1, "R7 one core strobe", core_frames - cf0, 1);
      chk(mem_frames - mf0 == 1, "R7 one memory strobe", mem_frames - mf0, 1);
      chk(core_cyc < mem_cyc, "R7 core before memory", core_cyc, mem_cyc);
      chk(core_bits == 13, "R4 core frame length", core_bits, 13);
      chk(mem_bits == 13, "R4 memory frame length", mem_bits, 13);
      chk(int'(core_val) == exp_m(m, 1'b0), "R5 core frame value", core_val, exp_m(m, 1'b0));
      chk(int'(mem_val) == exp_m(m, 1'b1), "R5 memory frame value", mem_val, exp_m(m, 1'b1));
      chk(!load_core_o && !load_mem_o, "R7 strobes returned low", {load_core_o, load_mem_o}, 0);
    end
    chk(gap_err == 0, "R8 pin change spacing", gap_err, 0);
    chk(pl_err == 0, "R6 preload high, strobes low at clock rise", pl_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o, "R1 busy/done at reset", {busy_o, done_o}, 0);
    chk(cur_mode_o == 1'b1, "R1 power-save at reset", cur_mode_o, 1);
    chk({sclk_o, sdata_o, preload_o, load_core_o, load_mem_o} == 5'b0, "R1 pins at reset",
        {sclk_o, sdata_o, preload_o, load_core_o, load_mem_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cur_mode_o == 1'b1 && !busy_o, "R1 idle after release", cur_mode_o, 1);
    do_req(1'b1, 1'b0);
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 2; k++)
        for (int q = 0; q < 2; q++)
          do_req(m[0], q[0]);
    do_req(1'b0, 1'b0);
    do_req(1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule